// File: doc/BRIEF.md
# Timer Compare/Capture Channel

This block is one general register of a timer channel together with the logic for its I/O pin. A 4-bit control word picks one of two jobs for the register. In compare mode, the register is checked against a free-running counter supplied from outside. On each match the pin is driven low, driven high or toggled. The pin starts from a level that is programmed when the control word is written. In capture mode, the register takes a snapshot of the counter. The snapshot is triggered by selected edges of an input pin or, in the cascade-capable variant, by a match or capture event from a neighbouring channel.

Every match and every capture raises a one-cycle flag. The same pulse is offered as an event for the next channel in a chain. Software writes the register through a simple write port and reads it back on a data output. The counter itself and its prescaler live outside this block.

Top module: `tmr_cc_chan`

## Requirements
- R1: After reset the control word is 0000, `pin_o`, `pin_oe_o`, `flag_o` and `evt_o` are 0, and `gr_o` is all ones.
- R2: A control write with bit 3 = 0 sets `pin_o` to control bit 2 at the clock edge that samples the write. This holds whatever bits 1:0 are.
- R3: `pin_oe_o` is 1 exactly when the stored control word has bit 3 = 0 and bits 1:0 not equal to 00.
- R4: In compare mode, when `cnt_i` equals `gr_o` at a clock edge, `flag_o` and `evt_o` are 1 for the following cycle only, including when bits 1:0 = 00.
- R5: On a compare match, bits 1:0 select the pin action: 01 drives 0, 10 drives 1, 11 inverts the level, 00 leaves it unchanged. A control write in the same cycle takes priority.
- R6: In capture mode with the pin as source, the pin passes through a two-flop synchronizer. With bits 1:0 = 00, a rising pin change sampled at edge k loads `gr_o` with the `cnt_i` value present at edge k+2. `flag_o` is then high for one cycle. A falling change captures nothing.
- R7: Capture mode with bits 1:0 = 01 captures on falling pin changes only, with the same latency as R6.
- R8: Capture mode with bits 1:0 = 10 or 11 captures on both pin edges.
- R9: When HAS_CASCADE = 1 and the control word is 1 1 x x, `casc_evt_i` high at an edge captures `cnt_i` at that same edge, and pin changes are ignored. In pin-sourced capture modes, `casc_evt_i` has no effect.
- R10: When HAS_CASCADE = 0, control bit 2 is ignored in capture mode and the pin remains the capture source, so 1100 behaves like 1000.
- R11: Register writes are accepted in capture mode and read back on `gr_o` on the next cycle. A later capture overwrites the written value, and a capture in the same cycle as a write wins.
- R12: In capture mode `pin_oe_o` is 0, and `cnt_i` equal to `gr_o` does not raise `flag_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cnt_i | input | CNT_W | Free-running counter value |
| gr_wr_i | input | 1 | Register write strobe |
| gr_wdata_i | input | CNT_W | Register write data |
| ctl_wr_i | input | 1 | Control word write strobe |
| ctl_i | input | 4 | Control word write data |
| cap_pin_i | input | 1 | Asynchronous capture pin |
| casc_evt_i | input | 1 | Match/capture event from the neighbouring channel |
| gr_o | output | CNT_W | Register contents |
| pin_o | output | 1 | Compare pin level |
| pin_oe_o | output | 1 | Compare pin output enable |
| flag_o | output | 1 | One-cycle match/capture flag |
| evt_o | output | 1 | Event passed to the next channel |

## Verification
A wrong stored control word shows on `pin_oe_o` in the cycle after the write. It also shows at the next match or pin edge, as a wrong pin action or a missing capture. A corrupted edge-detector history shows as a capture one cycle early or late. That error is visible on `gr_o` as a neighbouring counter value, because the bench changes `cnt_i` every cycle around an edge. A stuck pin register or flag shows at the first match after it, since every match is followed by a check one cycle later.

// File: rtl/tmr_cc_pkg.sv
package tmr_cc_pkg;

  localparam int unsigned CTL_W = 4;

  // Action taken by the pin on a compare match (control bits 1:0)
  typedef enum logic [1:0] {
    ACT_NONE   = 2'b00,
    ACT_LOW    = 2'b01,
    ACT_HIGH   = 2'b10,
    ACT_TOGGLE = 2'b11
  } cmp_act_e;

  // Capture trigger source
  typedef enum logic [1:0] {
    TRIG_RISE = 2'b00,
    TRIG_FALL = 2'b01,
    TRIG_BOTH = 2'b10,
    TRIG_CASC = 2'b11
  } cap_trig_e;

  typedef struct packed {
    logic      cap_mode;
    logic      init_lvl;
    logic      oe;
    cmp_act_e  act;
    cap_trig_e trig;
  } mode_dec_t;

endpackage

// File: rtl/tmr_cc_mode_dec.sv
module tmr_cc_mode_dec
  import tmr_cc_pkg::*;
#(
  parameter bit HAS_CASCADE = 1'b1
) (
  input  logic [CTL_W-1:0] ctl,
  output mode_dec_t        dec
);

  cap_trig_e trig;

  generate
    if (HAS_CASCADE) begin : g_casc
      always_comb begin
        if (ctl[2])      trig = TRIG_CASC;
        else if (ctl[1]) trig = TRIG_BOTH;
        else if (ctl[0]) trig = TRIG_FALL;
        else             trig = TRIG_RISE;
      end
    end else begin : g_pin_only
      always_comb begin
        if (ctl[1])      trig = TRIG_BOTH;
        else if (ctl[0]) trig = TRIG_FALL;
        else             trig = TRIG_RISE;
      end
    end
  endgenerate

  always_comb begin
    dec.cap_mode = ctl[3];
    dec.init_lvl = ctl[2];
    dec.act      = cmp_act_e'(ctl[1:0]);
    dec.oe       = !ctl[3] && (ctl[1:0] != 2'b00);
    dec.trig     = trig;
  end

endmodule

// File: rtl/tmr_cc_sync_edge.sv
module tmr_cc_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise,
  output logic fall
);

  logic [STAGES-1:0] chain_q, chain_d;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = din;
    end else begin : g_many
      always_comb chain_d = {chain_q[STAGES-2:0], din};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= chain_d;
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign rise = chain_q[STAGES-1] & ~prev_q;
  assign fall = ~chain_q[STAGES-1] & prev_q;

endmodule

// File: rtl/tmr_cc_pin_ctl.sv
module tmr_cc_pin_ctl
  import tmr_cc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load_en,
  input  logic     load_lvl,
  input  logic     match,
  input  cmp_act_e act,
  output logic     pin_q
);

  logic pin_d;

  // Control write outranks a match in the same cycle
  always_comb begin
    pin_d = pin_q;
    if (load_en) begin
      pin_d = load_lvl;
    end else if (match) begin
      unique case (act)
        ACT_LOW:    pin_d = 1'b0;
        ACT_HIGH:   pin_d = 1'b1;
        ACT_TOGGLE: pin_d = ~pin_q;
        default:    pin_d = pin_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= 1'b0;
    else        pin_q <= pin_d;
  end

endmodule

// File: rtl/tmr_cc_chan.sv
module tmr_cc_chan
  import tmr_cc_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter bit          HAS_CASCADE = 1'b1,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             gr_wr_i,
  input  logic [CNT_W-1:0] gr_wdata_i,
  input  logic             ctl_wr_i,
  input  logic [CTL_W-1:0] ctl_i,
  input  logic             cap_pin_i,
  input  logic             casc_evt_i,
  output logic [CNT_W-1:0] gr_o,
  output logic             pin_o,
  output logic             pin_oe_o,
  output logic             flag_o,
  output logic             evt_o
);

  localparam logic [CNT_W-1:0] GR_RST = '1;

  // Reset: asserted asynchronously, released on the clock
  logic rst_meta, rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q_n  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q_n  <= rst_meta;
    end
  end

  // Control word
  logic [CTL_W-1:0] ctl_q, ctl_d;
  always_comb ctl_d = ctl_wr_i ? ctl_i : ctl_q;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) ctl_q <= '0;
    else          ctl_q <= ctl_d;
  end

  mode_dec_t dec_cur, dec_new;

  tmr_cc_mode_dec #(.HAS_CASCADE(HAS_CASCADE)) u_dec_cur (
    .ctl (ctl_q),
    .dec (dec_cur)
  );

  tmr_cc_mode_dec #(.HAS_CASCADE(HAS_CASCADE)) u_dec_new (
    .ctl (ctl_i),
    .dec (dec_new)
  );

  // Pin edge detection
  logic pin_rise, pin_fall;
  tmr_cc_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_q_n),
    .din   (cap_pin_i),
    .rise  (pin_rise),
    .fall  (pin_fall)
  );

  // Match and capture events
  logic [CNT_W-1:0] gr_q, gr_d;
  logic             match, cap_evt, trig_hit;

  always_comb match = !dec_cur.cap_mode && (cnt_i == gr_q);

  always_comb begin
    unique case (dec_cur.trig)
      TRIG_RISE: trig_hit = pin_rise;
      TRIG_FALL: trig_hit = pin_fall;
      TRIG_BOTH: trig_hit = pin_rise | pin_fall;
      TRIG_CASC: trig_hit = casc_evt_i;
      default:   trig_hit = 1'b0;
    endcase
    cap_evt = dec_cur.cap_mode && trig_hit;
  end

  // General register: capture outranks a write
  always_comb begin
    gr_d = gr_q;
    if (cap_evt)      gr_d = cnt_i;
    else if (gr_wr_i) gr_d = gr_wdata_i;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) gr_q <= GR_RST;
    else          gr_q <= gr_d;
  end

  // Flag
  logic flag_q, flag_d;
  always_comb flag_d = match | cap_evt;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) flag_q <= 1'b0;
    else          flag_q <= flag_d;
  end

  // Pin level
  logic pin_q;
  tmr_cc_pin_ctl u_pin (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .load_en  (ctl_wr_i && !dec_new.cap_mode),
    .load_lvl (dec_new.init_lvl),
    .match    (match),
    .act      (dec_cur.act),
    .pin_q    (pin_q)
  );

  assign gr_o     = gr_q;
  assign pin_o    = pin_q;
  assign pin_oe_o = dec_cur.oe;
  assign flag_o   = flag_q;
  assign evt_o    = flag_q;

endmodule

// File: rtl/tmr_cc_chk.sv
module tmr_cc_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_q_n,
  input logic [3:0]       ctl_q,
  input logic             ctl_wr_i,
  input logic [3:0]       ctl_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [CNT_W-1:0] gr_o,
  input logic             pin_o,
  input logic             pin_oe_o,
  input logic             flag_o,
  input logic             cap_evt
);

  assert_init_level_R2: assert property (@(posedge clk) disable iff (!rst_q_n)
    (ctl_wr_i && !ctl_i[3]) |=> (pin_o == $past(ctl_i[2])));

  assert_match_flag_R4: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!ctl_q[3] && cnt_i == gr_o) |=> flag_o);

  assert_drive_high_R5: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!ctl_q[3] && ctl_q[1:0] == 2'b10 && cnt_i == gr_o && !ctl_wr_i) |=> pin_o);

  assert_drive_low_R5: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!ctl_q[3] && ctl_q[1:0] == 2'b01 && cnt_i == gr_o && !ctl_wr_i) |=> !pin_o);

  assert_toggle_R5: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!ctl_q[3] && ctl_q[1:0] == 2'b11 && cnt_i == gr_o && !ctl_wr_i)
    |=> (pin_o != $past(pin_o)));

  assert_capture_load_R6: assert property (@(posedge clk) disable iff (!rst_q_n)
    cap_evt |=> (gr_o == $past(cnt_i) && flag_o));

  assert_cap_no_oe_R12: assert property (@(posedge clk) disable iff (!rst_q_n)
    ctl_q[3] |-> !pin_oe_o);

  assert_cap_no_match_R12: assert property (@(posedge clk) disable iff (!rst_q_n)
    (ctl_q[3] && !cap_evt && !ctl_wr_i) |=> !flag_o);

endmodule

bind tmr_cc_chan tmr_cc_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_q_n  (rst_q_n),
  .ctl_q    (ctl_q),
  .ctl_wr_i (ctl_wr_i),
  .ctl_i    (ctl_i),
  .cnt_i    (cnt_i),
  .gr_o     (gr_o),
  .pin_o    (pin_o),
  .pin_oe_o (pin_oe_o),
  .flag_o   (flag_o),
  .cap_evt  (cap_evt)
);

// File: tb/tb_tmr_cc_chan.sv
module tb_tmr_cc_chan;

  localparam int unsigned W = 16;

  logic         clk;
  logic         rst_n;
  logic [W-1:0] cnt;
  logic         gr_wr;
  logic [W-1:0] gr_wdata;
  logic         ctl_wr;
  logic [3:0]   ctl;
  logic         cap_pin;
  logic         casc;

  logic [W-1:0] gr, nc_gr;
  logic         pin, pin_oe, flag, evt;
  logic         nc_pin, nc_oe, nc_flag, nc_evt;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  tmr_cc_chan #(.CNT_W(W), .HAS_CASCADE(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .cnt_i(cnt), .gr_wr_i(gr_wr), .gr_wdata_i(gr_wdata),
    .ctl_wr_i(ctl_wr), .ctl_i(ctl), .cap_pin_i(cap_pin), .casc_evt_i(casc),
    .gr_o(gr), .pin_o(pin), .pin_oe_o(pin_oe), .flag_o(flag), .evt_o(evt)
  );

  tmr_cc_chan #(.CNT_W(W), .HAS_CASCADE(1'b0)) dut_nc (
    .clk(clk), .rst_n(rst_n), .cnt_i(cnt), .gr_wr_i(gr_wr), .gr_wdata_i(gr_wdata),
    .ctl_wr_i(ctl_wr), .ctl_i(ctl), .cap_pin_i(cap_pin), .casc_evt_i(casc),
    .gr_o(nc_gr), .pin_o(nc_pin), .pin_oe_o(nc_oe), .flag_o(nc_flag), .evt_o(nc_evt)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_ctl(input logic [3:0] v);
    ctl = v; ctl_wr = 1'b1;
    tick();
    ctl_wr = 1'b0;
  endtask

  task automatic write_gr(input logic [W-1:0] v);
    gr_wdata = v; gr_wr = 1'b1;
    tick();
    gr_wr = 1'b0;
  endtask

  // Change the pin, step the counter each cycle, check capture at third edge
  task automatic pin_to(input logic v, input logic [W-1:0] base,
                        input logic exp_cap, input logic exp_nc, input string req);
    logic [W-1:0] r0, r0n;
    r0 = gr; r0n = nc_gr;
    cap_pin = v; cnt = base;
    tick();
    cnt = base + 1;
    tick();
    check({req, " early flag"}, 32'(flag), 32'd0);
    cnt = base + 2;
    tick();
    check({req, " reg"}, 32'(gr), exp_cap ? 32'(base + 2) : 32'(r0));
    check({req, " flag"}, 32'(flag), 32'(exp_cap));
    check({req, " nc reg"}, 32'(nc_gr), exp_nc ? 32'(base + 2) : 32'(r0n));
    check({req, " nc flag"}, 32'(nc_flag), 32'(exp_nc));
    cnt = base + 3;
    tick();
    check({req, " flag one cycle"}, 32'(flag), 32'd0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(4);
    check("R1 pin", 32'(pin), 32'd0);
    check("R1 oe", 32'(pin_oe), 32'd0);
    check("R1 flag", 32'(flag), 32'd0);
    check("R1 evt", 32'(evt), 32'd0);
    check("R1 reg", 32'(gr), 32'hFFFF);
    check("R1 nc reg", 32'(nc_gr), 32'hFFFF);
  endtask

  task automatic t_init_level;
    write_ctl(4'b0110);
    check("R2 init 1", 32'(pin), 32'd1);
    check("R3 oe on", 32'(pin_oe), 32'd1);
    write_ctl(4'b0001);
    check("R2 init 0", 32'(pin), 32'd0);
    write_ctl(4'b0100);
    check("R2 init 1 disabled", 32'(pin), 32'd1);
    check("R3 oe off", 32'(pin_oe), 32'd0);
  endtask

  task automatic t_compare;
    write_gr(16'h0010);
    write_ctl(4'b0101);
    cnt = 16'h000F; tick();
    check("R4 no match flag", 32'(flag), 32'd0);
    check("R2 held", 32'(pin), 32'd1);
    cnt = 16'h0010; tick();
    check("R4 match flag", 32'(flag), 32'd1);
    check("R4 match evt", 32'(evt), 32'd1);
    check("R5 drive low", 32'(pin), 32'd0);
    cnt = 16'h0011; tick();
    check("R4 flag one cycle", 32'(flag), 32'd0);
    write_ctl(4'b0010);
    cnt = 16'h0010; tick();
    check("R5 drive high", 32'(pin), 32'd1);
    cnt = 16'h0011;
    write_ctl(4'b0011);
    check("R5 toggle start", 32'(pin), 32'd0);
    cnt = 16'h0010; tick();
    check("R5 toggle 1", 32'(pin), 32'd1);
    cnt = 16'h0011; tick();
    check("R5 toggle hold", 32'(pin), 32'd1);
    cnt = 16'h0010; tick();
    check("R5 toggle 2", 32'(pin), 32'd0);
    cnt = 16'h0011;
    write_ctl(4'b0100);
    cnt = 16'h0010; tick();
    check("R4 flag when disabled", 32'(flag), 32'd1);
    check("R5 no action", 32'(pin), 32'd1);
    check("R3 oe off", 32'(pin_oe), 32'd0);
    cnt = 16'h0011; tick();
  endtask

  task automatic t_capture_edges;
    write_ctl(4'b1000);
    check("R12 oe in capture", 32'(pin_oe), 32'd0);
    cnt = 16'h0010; tick();
    check("R12 no compare flag", 32'(flag), 32'd0);
    check("R12 reg kept", 32'(gr), 32'h0010);
    pin_to(1'b1, 16'h0100, 1'b1, 1'b1, "R6 rise");
    pin_to(1'b0, 16'h0200, 1'b0, 1'b0, "R6 fall ignored");
    write_ctl(4'b1001);
    pin_to(1'b1, 16'h0300, 1'b0, 1'b0, "R7 rise ignored");
    pin_to(1'b0, 16'h0400, 1'b1, 1'b1, "R7 fall");
    write_ctl(4'b1010);
    pin_to(1'b1, 16'h0500, 1'b1, 1'b1, "R8 rise");
    pin_to(1'b0, 16'h0600, 1'b1, 1'b1, "R8 fall");
    write_ctl(4'b1011);
    pin_to(1'b1, 16'h0700, 1'b1, 1'b1, "R8 mode 11");
  endtask

  task automatic t_cascade;
    write_ctl(4'b1100);
    cnt = 16'h0777; casc = 1'b1;
    gr_wdata = 16'h5555; gr_wr = 1'b1;
    tick();
    casc = 1'b0; gr_wr = 1'b0;
    check("R9 cascade capture", 32'(gr), 32'h0777);
    check("R9 cascade flag", 32'(flag), 32'd1);
    check("R9 cascade evt", 32'(evt), 32'd1);
    check("R11 capture beats write", 32'(gr), 32'h0777);
    check("R10 nc write kept", 32'(nc_gr), 32'h5555);
    check("R10 nc no flag", 32'(nc_flag), 32'd0);
    tick();
    pin_to(1'b0, 16'h0800, 1'b0, 1'b0, "R10 nc fall ignored");
    pin_to(1'b1, 16'h0900, 1'b0, 1'b1, "R9 pin ignored R10 nc rise");
    write_ctl(4'b1000);
    cnt = 16'h0A00; casc = 1'b1;
    tick();
    casc = 1'b0;
    check("R9 cascade ignored in pin mode", 32'(gr), 32'h0777);
    check("R9 no flag in pin mode", 32'(flag), 32'd0);
    tick();
  endtask

  task automatic t_write_capture;
    write_gr(16'h1234);
    check("R11 write in capture", 32'(gr), 32'h1234);
    pin_to(1'b0, 16'h0B00, 1'b0, 1'b0, "R11 no capture keeps write");
    check("R11 still written", 32'(gr), 32'h1234);
    pin_to(1'b1, 16'h0C00, 1'b1, 1'b1, "R11 overwrite");
  endtask

  initial begin
    rst_n = 1'b0; cnt = '0; gr_wr = 1'b0; gr_wdata = '0;
    ctl_wr = 1'b0; ctl = 4'b0000; cap_pin = 1'b0; casc = 1'b0;
    t_reset();
    t_init_level();
    t_compare();
    t_capture_edges();
    t_cascade();
    t_write_capture();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule